// File: doc/BRIEF.md
# Parallel Two-Rank Register Access Port

This block is the slave side of a register access port that a host drives over an asynchronous parallel bus. The host presents an address and a data byte and pulses active-low write, read and chip-select strobes. A mode input chooses whether the parallel bus is in use at all. The block brings the strobes into its local clock and detects the write edge. It stores each written byte in a holding (first-rank) register. The core-side logic sees only the active (second-rank) copies.

Holding registers move into the active registers as one group when the core pulses a commit input. This lets a set of settings take effect in the same cycle. Reads return the active value at the selected address. The data bus is modelled as a value plus an output enable. Read takes precedence over write, and a group of addresses at the top of the map can be written but not read back.

Top module: `parbus_regport`

## Requirements
- R1: After reset, `data_oe` is 0, `data_out` is 0x00 and every active register is 0x00.
- R2: A falling edge of `we_n` while `cs_n` is low, `re_n` is high and `ser_sel` is low stores `data_i` into the holding register at `addr_i`. The active registers do not change until a commit.
- R3: A one-cycle `commit` pulse copies every holding register into its active register in that clock cycle. A read of a read/write address (0 to NUM_REGS-NUM_WO-1, 0 to 11 by default) returns that active value.
- R4: Keeping `we_n` low produces one capture only. Data changed while it stays low is not stored.
- R5: With `cs_n` high, writes have no effect and `data_oe` stays 0.
- R6: With `ser_sel` high, writes have no effect and `data_oe` stays 0.
- R7: A `we_n` falling edge while `re_n` is low modifies no holding register.
- R8: Write-only addresses (NUM_REGS-NUM_WO to NUM_REGS-1, 12 to 15 by default) accept writes, which reach `active_regs` on commit. They read back as 0x00.
- R9: Addresses at or above NUM_REGS (16 by default) read back as 0x00. Writes to them change no register.
- R10: `data_oe` rises three clock edges after `re_n` falls: two synchronizer stages and the output register. It falls three edges after `re_n` rises. `data_out` is 0x00 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | High disables the parallel port |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe; its falling edge captures |
| re_n | input | 1 | Active-low read strobe |
| addr_i | input | ADDR_W | Register address |
| data_i | input | DATA_W | Write data from the host |
| commit | input | 1 | Copies all holding registers into the active registers |
| data_out | output | DATA_W | Read-back value |
| data_oe | output | 1 | Enable for driving the data bus |
| active_regs | output | NUM_REGS*DATA_W | Active register values, register k at bits [k*DATA_W +: DATA_W] |

## Verification
The assertions assume that the host keeps `addr_i` and `data_i` steady from before a strobe edge until the synchronized strobe has acted, since those buses are sampled without a synchronizer. They also assume `commit` is a synchronous pulse in the local clock domain. The stimulus changes every bus input on the falling clock edge. It holds each strobe level for at least four clock cycles and never moves the address or data while a strobe is active, except in the held-write test, where only the data moves.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [1:0] {
        RB_RW   = 2'd0,
        RB_WO   = 2'd1,
        RB_NONE = 2'd2
    } rb_class_e;

    // Address class: read/write below n_rw, write-only up to n_regs, unmapped above.
    function automatic rb_class_e classify(input logic [31:0] a,
                                           input logic [31:0] n_regs,
                                           input logic [31:0] n_rw);
        if (a >= n_regs) return RB_NONE;
        if (a >= n_rw)   return RB_WO;
        return RB_RW;
    endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/regport_strobe.sv
module regport_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic we_s_n,
    input  logic re_s_n,
    input  logic cs_s_n,
    input  logic mode_s,
    output logic wr_fire,
    output logic rd_act
);

    typedef struct packed {
        logic we_prev;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    port_on;

    always_comb begin
        port_on = !mode_s && !cs_s_n;
        rd_act  = port_on && !re_s_n;
        // Capture needs a high-to-low WE step with the read strobe released.
        wr_fire = port_on && re_s_n && st_q.we_prev && !we_s_n;
        st_d         = st_q;
        st_d.we_prev = we_s_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.we_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/regport_bank.sv
module regport_bank
    import regport_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter int               NUM_REGS = 16,
    parameter int               NUM_WO   = 4,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_fire,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         commit,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [NUM_REGS*DATA_W-1:0]   first_flat,
    output logic [NUM_REGS*DATA_W-1:0]   active_flat,
    output logic [DATA_W-1:0]            rd_value
);

    localparam int NUM_RW = NUM_REGS - NUM_WO;
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] first;
        logic [NUM_REGS-1:0][DATA_W-1:0] active;
    } bank_t;

    bank_t      st_d, st_q;
    rb_class_e  wr_cls, rd_cls;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        wr_cls = classify(32'(wr_addr), 32'(NUM_REGS), 32'(NUM_RW));
        rd_cls = classify(32'(rd_addr), 32'(NUM_REGS), 32'(NUM_RW));
        wr_idx = wr_addr[IDX_W-1:0];
        rd_idx = rd_addr[IDX_W-1:0];

        st_d = st_q;
        // Commit samples holding values as they stood before this cycle's write.
        if (commit) begin
            st_d.active = st_q.first;
        end
        if (wr_fire && (wr_cls != RB_NONE)) begin
            st_d.first[wr_idx] = wr_data;
        end

        rd_value = '0;
        if (rd_cls == RB_RW) begin
            rd_value = st_q.active[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.first  <= {NUM_REGS{RST_VAL}};
            st_q.active <= {NUM_REGS{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
            assign first_flat[k*DATA_W +: DATA_W]  = st_q.first[k];
            assign active_flat[k*DATA_W +: DATA_W] = st_q.active[k];
        end
    endgenerate

endmodule

// File: rtl/parbus_regport.sv
module parbus_regport #(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter int               NUM_REGS = 16,
    parameter int               NUM_WO   = 4,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_sel,
    input  logic                       cs_n,
    input  logic                       we_n,
    input  logic                       re_n,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic                       commit,
    output logic [DATA_W-1:0]          data_out,
    output logic                       data_oe,
    output logic [NUM_REGS*DATA_W-1:0] active_regs
);

    localparam int CTRL_W = 4;

    logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
    logic              mode_s, cs_s_n, re_s_n, we_s_n;
    logic              wr_fire, rd_act;
    logic [DATA_W-1:0] rd_value;
    logic [NUM_REGS*DATA_W-1:0] first_flat;

    assign ctrl_raw = {ser_sel, cs_n, re_n, we_n};

    regport_sync #(
        .W       (CTRL_W),
        .RST_VAL ({CTRL_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctrl_raw),
        .sync_o  (ctrl_s)
    );

    assign {mode_s, cs_s_n, re_s_n, we_s_n} = ctrl_s;

    regport_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_s_n  (we_s_n),
        .re_s_n  (re_s_n),
        .cs_s_n  (cs_s_n),
        .mode_s  (mode_s),
        .wr_fire (wr_fire),
        .rd_act  (rd_act)
    );

    regport_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .NUM_WO   (NUM_WO),
        .RST_VAL  (RST_VAL)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_addr     (addr_i),
        .wr_data     (data_i),
        .commit      (commit),
        .rd_addr     (addr_i),
        .first_flat  (first_flat),
        .active_flat (active_regs),
        .rd_value    (rd_value)
    );

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] dout;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.oe   = rd_act;
        out_d.dout = rd_act ? rd_value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.oe   <= 1'b0;
            out_q.dout <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_oe  = out_q.oe;
    assign data_out = out_q.dout;

endmodule

// File: rtl/parbus_regport_chk.sv
module parbus_regport_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int NUM_WO   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       commit,
    input logic                       data_oe,
    input logic [DATA_W-1:0]          data_out,
    input logic [ADDR_W-1:0]          addr_i,
    input logic [NUM_REGS*DATA_W-1:0] active_regs,
    input logic [NUM_REGS*DATA_W-1:0] first_flat,
    input logic                       rd_act,
    input logic                       mode_s
);

    localparam int NUM_RW = NUM_REGS - NUM_WO;

    // Active copies move only on a commit.
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_regs));

    // A commit lands the holding values in the active copies.
    assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_regs == $past(first_flat)));

    // Serial mode leaves the holding registers alone.
    assert_mode_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |=> $stable(first_flat));

    // An active read blocks every holding-register update.
    assert_read_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> $stable(first_flat));

    // Write-only and unmapped addresses return zero.
    assert_hidden_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && (32'(addr_i) >= NUM_RW)) |=> (data_out == '0));

    // Bus value is zero whenever it is not driven.
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

endmodule

bind parbus_regport parbus_regport_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .NUM_WO   (NUM_WO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .addr_i      (addr_i),
    .active_regs (active_regs),
    .first_flat  (first_flat),
    .rd_act      (rd_act),
    .mode_s      (mode_s)
);

// File: tb/parbus_regport_bench.sv
module parbus_regport_bench;

    localparam int NR = 16;
    localparam int NRW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b0;
    logic cs_n = 1'b1;
    logic we_n = 1'b1;
    logic re_n = 1'b1;
    logic [7:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic commit = 1'b0;
    logic [7:0] data_out;
    logic data_oe;
    logic [NR*8-1:0] active_regs;

    always #5 clk = ~clk;

    parbus_regport u_parbus_regport (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .cs_n(cs_n),
        .we_n(we_n), .re_n(re_n), .addr_i(addr_i), .data_i(data_i),
        .commit(commit), .data_out(data_out), .data_oe(data_oe),
        .active_regs(active_regs)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_first [NR];
    logic [7:0] m_active [NR];

    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NR*8-1:0] model_active();
        logic [NR*8-1:0] v;
        for (int k = 0; k < NR; k++) v[k*8 +: 8] = m_active[k];
        return v;
    endfunction

    // Monitor: each rise of the bus enable consumes one expected read value.
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && data_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R6 unexpected drive", {120'd0, data_out}, 128'd0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(data_out == e, t, {120'd0, data_out}, {120'd0, e});
            end
        end
        oe_prev = data_oe;
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic [7:0] d_late);
        addr_i = a;
        data_i = d;
        tick(1);
        we_n = 1'b0;
        tick(4);
        data_i = d_late;
        tick(4);
        we_n = 1'b1;
        tick(4);
        if (!cs_n && !ser_sel && re_n && a < NR) m_first[a] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        bit driven;
        bit saw_oe;
        driven = !cs_n && !ser_sel;
        saw_oe = 1'b0;
        addr_i = a;
        tick(1);
        if (driven) begin
            exp_q.push_back((a < NRW) ? m_active[a] : 8'h00);
            tag_q.push_back(req);
        end
        re_n = 1'b0;
        repeat (5) begin
            tick(1);
            if (data_oe) saw_oe = 1'b1;
        end
        re_n = 1'b1;
        tick(4);
        if (!driven) check(!saw_oe, req, {127'd0, saw_oe}, 128'd0);
    endtask

    task automatic do_commit();
        commit = 1'b1;
        tick(1);
        commit = 1'b0;
        for (int k = 0; k < NR; k++) m_active[k] = m_first[k];
        tick(1);
        check(active_regs == model_active(), "R3 commit copy", active_regs, model_active());
    endtask

    initial begin
        for (int k = 0; k < NR; k++) begin
            m_first[k] = 8'h00;
            m_active[k] = 8'h00;
        end
        tick(3);
        check(data_oe == 1'b0, "R1 oe reset", {127'd0, data_oe}, 128'd0);
        check(data_out == 8'h00, "R1 data reset", {120'd0, data_out}, 128'd0);
        check(active_regs == '0, "R1 regs reset", active_regs, 128'd0);
        rst_n = 1'b1;
        tick(3);
        cs_n = 1'b0;

        // R2: fill every register; active copies must not move yet.
        for (int k = 0; k < NR; k++) begin
            logic [7:0] v;
            v = 8'(k * 29) ^ 8'h5A;
            bus_write(8'(k), v, v);
        end
        check(active_regs == '0, "R2 active held before commit", active_regs, 128'd0);
        do_commit();

        // R3, R8, R9: read the whole map and beyond.
        for (int k = 0; k < 18; k++) bus_read(8'(k), (k < NRW) ? "R3 readback" : (k < NR) ? "R8 write-only zero" : "R9 unmapped zero");
        bus_read(8'hFF, "R9 unmapped top zero");

        // R9: writes above the map change nothing.
        bus_write(8'h20, 8'hEE, 8'hEE);
        bus_write(8'hFF, 8'hDD, 8'hDD);
        do_commit();
        check(active_regs == model_active(), "R9 unmapped write ignored", active_regs, model_active());

        // R4: held WE with changing data captures the first value only.
        bus_write(8'd2, 8'hA5, 8'h3C);
        do_commit();
        bus_read(8'd2, "R4 single capture");

        // R5: deselected.
        cs_n = 1'b1;
        bus_write(8'd3, 8'h77, 8'h77);
        bus_read(8'd3, "R5 no drive when deselected");
        cs_n = 1'b0;
        tick(3);
        do_commit();
        check(active_regs[3*8 +: 8] == m_active[3], "R5 write ignored", {120'd0, active_regs[3*8 +: 8]}, {120'd0, m_active[3]});

        // R6: serial mode selected.
        ser_sel = 1'b1;
        tick(3);
        bus_write(8'd4, 8'h99, 8'h99);
        bus_read(8'd4, "R6 no drive in serial mode");
        ser_sel = 1'b0;
        tick(3);
        do_commit();
        check(active_regs[4*8 +: 8] == m_active[4], "R6 write ignored", {120'd0, active_regs[4*8 +: 8]}, {120'd0, m_active[4]});

        // R7: WE falls while RE is low; RE released while WE still low.
        addr_i = 8'd5;
        data_i = 8'h42;
        tick(1);
        exp_q.push_back(m_active[5]);
        tag_q.push_back("R7 read during write");
        re_n = 1'b0;
        tick(5);
        we_n = 1'b0;
        tick(5);
        re_n = 1'b1;
        tick(5);
        we_n = 1'b1;
        tick(4);
        do_commit();
        check(active_regs[5*8 +: 8] == m_active[5], "R7 read priority", {120'd0, active_regs[5*8 +: 8]}, {120'd0, m_active[5]});

        // R8: write-only register accepts data but reads zero.
        bus_write(8'd13, 8'hC3, 8'hC3);
        do_commit();
        check(active_regs[13*8 +: 8] == 8'hC3, "R8 write-only stored", {120'd0, active_regs[13*8 +: 8]}, 128'hC3);
        bus_read(8'd13, "R8 write-only reads zero");

        // R10: enable timing relative to RE.
        addr_i = 8'd0;
        tick(1);
        exp_q.push_back(m_active[0]);
        tag_q.push_back("R10 read value");
        re_n = 1'b0;
        tick(2);
        check(data_oe == 1'b0, "R10 oe not yet", {127'd0, data_oe}, 128'd0);
        tick(1);
        check(data_oe == 1'b1, "R10 oe after three edges", {127'd0, data_oe}, 128'd1);
        tick(2);
        re_n = 1'b1;
        tick(2);
        check(data_oe == 1'b1, "R10 oe held", {127'd0, data_oe}, 128'd1);
        tick(1);
        check(data_oe == 1'b0, "R10 oe released", {127'd0, data_oe}, 128'd0);
        check(data_out == 8'h00, "R10 idle data zero", {120'd0, data_out}, 128'd0);
        tick(3);

        // Final sweep of the read/write map.
        for (int k = 0; k < NRW; k++) bus_read(8'(k), "R3 final readback");
        tick(4);
        check(exp_q.size() == 0, "R10 all expected reads driven", 128'(exp_q.size()), 128'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule